// File: doc/BRIEF.md
# Block Write-Protect Lock Controller

This block holds a write-protection state for every erase block of a flash array and carries out range lock commands against that table. Software first writes a first-block and a last-block address register, then issues a command code. The controller walks the range one block per clock, rewriting each entry under lock-tight precedence. While the walk runs it holds `busy` high. At the end it raises a sticky completion interrupt. It records an out-of-range walk in `cmd_err` and keeps the most recently written state on `wp_status`.

Each block is in one of three states. Lock-tight outranks the other two. Lock and unlock walks end as soon as they meet a lock-tight block. The lock-tight walk passes over unlocked blocks and keeps going. A query port reads any entry of the table, so its contents can be inspected from outside.

The controller is a two-state machine. `ST_IDLE` takes the transition *accept* into `ST_WALK` when a known command arrives. `ST_WALK` stays in place on *advance*, where a block is processed and the index steps forward. It returns to `ST_IDLE` on one of three transitions: *done* (the index has passed the last block), *fault* (the index has reached the block count) or *blocked* (a lock-tight block was met by a lock or unlock walk).

Top module: `wp_lock_ctrl`

## Requirements
- R1: The state codes are lock-tight = 3'b001, locked = 3'b010 and unlocked = 3'b100. After reset every block is locked, `wp_status` is 3'b010, and `busy`, `cmd_err` and `irq` are 0.
- R2: Command 8'h23 sets every block from the first address to the last address, both included, to unlocked.
- R3: Command 8'h2A sets every block from the first address to the last address, both included, to locked.
- R4: A walk for 8'h23, 8'h27 or 8'h2A ends at the first lock-tight block it meets. That block and every block after it keep their state.
- R5: Command 8'h2C makes each block in the range lock-tight, except unlocked blocks, which stay unlocked. The walk continues past them.
- R6: Command 8'h27 walks from block 0 to block NBLK-1 and unlocks each block, subject to R4.
- R7: A walk that reaches an index at or above NBLK sets `cmd_err` and ends there. `cmd_err` clears when the next command is accepted.
- R8: A write to the first-address register also loads the last-address register with the same value. Both registers keep only the low AW bits of `addr_wdata`, with AW = clog2(NBLK). A write to the last-address register alone changes only that register.
- R9: `wp_status` takes the new state of each block written. It stays unchanged when a command writes no block.
- R10: `irq` goes to 1 in the cycle where `busy` falls after every accepted command. It stays at 1 until `irq_clr` is asserted.
- R11: A command is accepted from idle in one cycle and processes one block per cycle. `busy` is high for one cycle per block examined, plus one cycle when the range runs out. Command codes other than the four above, and any command issued while `busy` is high, have no effect.
- R12: A range whose first address is above its last address changes no block, takes one busy cycle and still raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; every block becomes locked |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| first_wr | input | 1 | Write strobe for the first-block register (also loads the last-block register) |
| last_wr | input | 1 | Write strobe for the last-block register |
| addr_wdata | input | DW | Address write data |
| irq_clr | input | 1 | Clears the completion interrupt |
| qry_idx | input | AW | Table query index |
| qry_state | output | 3 | State of block `qry_idx` |
| first_addr | output | AW | First-block register |
| last_addr | output | AW | Last-block register |
| busy | output | 1 | Walk in progress |
| cmd_err | output | 1 | Last walk ran past the block count |
| wp_status | output | 3 | Most recently written block state |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench instantiates 40 blocks behind a 6-bit address, so indices 40 to 63 can be reached. A design that masks these indices or wraps them round would miss the error, or would corrupt blocks at the low end of the table.

The bench runs a lock-tight walk across a mix of unlocked and locked blocks. A design that stops at the first unlocked block would leave later locked blocks unchanged. A design that tightens unlocked blocks would lose them for good.

The bench also covers unlock and lock walks that meet a lock-tight block, ranges with first above last, unknown codes, and commands issued while busy. It counts busy cycles, which exposes a walk that runs one block too far or one block too short.

// File: rtl/wpl_pkg.sv
package wpl_pkg;
    // Per-block protection codes
    localparam logic [2:0] WP_TIGHT  = 3'b001;
    localparam logic [2:0] WP_LOCKED = 3'b010;
    localparam logic [2:0] WP_OPEN   = 3'b100;

    // Command codes
    localparam logic [7:0] OP_UNLOCK_RANGE = 8'h23;
    localparam logic [7:0] OP_UNLOCK_ALL   = 8'h27;
    localparam logic [7:0] OP_LOCK_RANGE   = 8'h2A;
    localparam logic [7:0] OP_TIGHT_RANGE  = 8'h2C;

    typedef enum logic [1:0] {ACT_OPEN, ACT_LOCK, ACT_TIGHT} act_t;
    typedef enum logic {ST_IDLE, ST_WALK} walk_st_t;
endpackage

// File: rtl/wpl_addr_regs.sv
module wpl_addr_regs #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_first,
    input  logic          set_last,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] first_q,
    output logic [AW-1:0] last_q
);
    logic [AW-1:0] masked;
    assign masked = wdata[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
        end else begin
            if (set_first) begin
                first_q <= masked;
                last_q  <= masked;
            end
            if (set_last) begin
                last_q <= masked;
            end
        end
    end
endmodule

// File: rtl/wpl_state_table.sv
module wpl_state_table
    import wpl_pkg::*;
#(
    parameter int NBLK = 64,
    parameter int IW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [2:0]    wval,
    input  logic [IW-1:0] ridx,
    output logic [2:0]    rval,
    input  logic [IW-1:0] qidx,
    output logic [2:0]    qval
);
    logic [2:0] ent [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[g] <= WP_LOCKED;
            end else if (we && widx == IW'(g)) begin
                ent[g] <= wval;
            end
        end
    end

    always_comb begin
        rval = WP_LOCKED;
        qval = WP_LOCKED;
        for (int i = 0; i < NBLK; i++) begin
            if (ridx == IW'(i)) rval = ent[i];
            if (qidx == IW'(i)) qval = ent[i];
        end
    end
endmodule

// File: rtl/wpl_walker.sv
module wpl_walker
    import wpl_pkg::*;
#(
    parameter int NBLK = 64,
    parameter int AW   = 6,
    parameter int IW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_code,
    input  logic [AW-1:0] first_idx,
    input  logic [AW-1:0] last_idx,
    input  logic          irq_clr,
    input  logic [2:0]    cur_state,
    output logic [IW-1:0] cur_idx,
    output logic          tbl_we,
    output logic [2:0]    tbl_val,
    output logic          busy,
    output logic          cmd_err,
    output logic [2:0]    wp_status,
    output logic          irq
);
    localparam logic [IW-1:0] TOP_IDX = IW'(NBLK - 1);
    localparam logic [IW-1:0] CNT_IDX = IW'(NBLK);

    walk_st_t      st, nxt;
    act_t          act, dec_act;
    logic          dec_known, dec_all;
    logic [IW-1:0] stop_idx;
    logic          accept, finish, fault;

    // Command decode
    always_comb begin
        dec_known = 1'b1;
        dec_all   = 1'b0;
        dec_act   = ACT_LOCK;
        unique case (cmd_code)
            OP_UNLOCK_RANGE: dec_act = ACT_OPEN;
            OP_UNLOCK_ALL:   begin dec_act = ACT_OPEN; dec_all = 1'b1; end
            OP_LOCK_RANGE:   dec_act = ACT_LOCK;
            OP_TIGHT_RANGE:  dec_act = ACT_TIGHT;
            default:         dec_known = 1'b0;
        endcase
    end

    // Next state and per-block action
    always_comb begin
        nxt     = st;
        accept  = 1'b0;
        finish  = 1'b0;
        fault   = 1'b0;
        tbl_we  = 1'b0;
        tbl_val = WP_LOCKED;
        unique case (st)
            ST_IDLE: begin
                if (cmd_valid && dec_known) begin
                    accept = 1'b1;
                    nxt    = ST_WALK;
                end
            end
            ST_WALK: begin
                if (cur_idx > stop_idx) begin
                    finish = 1'b1;                       // done
                end else if (cur_idx >= CNT_IDX) begin
                    finish = 1'b1;                       // fault
                    fault  = 1'b1;
                end else if (cur_state == WP_TIGHT && act != ACT_TIGHT) begin
                    finish = 1'b1;                       // blocked
                end else begin                           // advance
                    unique case (act)
                        ACT_OPEN:  begin tbl_we = 1'b1; tbl_val = WP_OPEN; end
                        ACT_LOCK:  begin tbl_we = 1'b1; tbl_val = WP_LOCKED; end
                        ACT_TIGHT: begin
                            tbl_we  = (cur_state != WP_OPEN);
                            tbl_val = WP_TIGHT;
                        end
                        default:   tbl_we = 1'b0;
                    endcase
                end
                if (finish) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Outputs and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            stop_idx  <= '0;
            act       <= ACT_OPEN;
            cmd_err   <= 1'b0;
            wp_status <= WP_LOCKED;
            irq       <= 1'b0;
        end else begin
            if (accept) begin
                act      <= dec_act;
                cur_idx  <= dec_all ? '0 : IW'(first_idx);
                stop_idx <= dec_all ? TOP_IDX : IW'(last_idx);
                cmd_err  <= 1'b0;
            end else if (st == ST_WALK && !finish) begin
                cur_idx <= cur_idx + 1'b1;
            end
            if (fault)  cmd_err   <= 1'b1;
            if (tbl_we) wp_status <= tbl_val;
            if (finish)       irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

    assign busy = (st == ST_WALK);
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
    import wpl_pkg::*;
#(
    parameter int  NBLK = 64,
    parameter int  DW   = 16,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_code,
    input  logic          first_wr,
    input  logic          last_wr,
    input  logic [DW-1:0] addr_wdata,
    input  logic          irq_clr,
    input  logic [AW-1:0] qry_idx,
    output logic [2:0]    qry_state,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] last_addr,
    output logic          busy,
    output logic          cmd_err,
    output logic [2:0]    wp_status,
    output logic          irq
);
    localparam int IW = AW + 1;

    logic [IW-1:0] cur_idx;
    logic [2:0]    cur_state;
    logic          tbl_we;
    logic [2:0]    tbl_val;

    wpl_addr_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .set_first(first_wr), .set_last(last_wr), .wdata(addr_wdata),
        .first_q(first_addr), .last_q(last_addr)
    );

    wpl_state_table #(.NBLK(NBLK), .IW(IW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .widx(cur_idx), .wval(tbl_val),
        .ridx(cur_idx), .rval(cur_state),
        .qidx(IW'(qry_idx)), .qval(qry_state)
    );

    wpl_walker #(.NBLK(NBLK), .AW(AW), .IW(IW)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .first_idx(first_addr), .last_idx(last_addr),
        .irq_clr(irq_clr), .cur_state(cur_state),
        .cur_idx(cur_idx), .tbl_we(tbl_we), .tbl_val(tbl_val),
        .busy(busy), .cmd_err(cmd_err), .wp_status(wp_status), .irq(irq)
    );
endmodule

// File: rtl/wpl_checker.sv
module wpl_checker
    import wpl_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [7:0]    cmd_code,
    input logic          first_wr,
    input logic          last_wr,
    input logic [AW-1:0] first_addr,
    input logic [AW-1:0] last_addr,
    input logic          busy,
    input logic          cmd_err,
    input logic [2:0]    wp_status,
    input logic          irq,
    input logic          tbl_we,
    input logic [2:0]    cur_state,
    input logic [2:0]    tbl_val
);
    logic known;
    assign known = (cmd_code == OP_UNLOCK_RANGE) || (cmd_code == OP_UNLOCK_ALL) ||
                   (cmd_code == OP_LOCK_RANGE)   || (cmd_code == OP_TIGHT_RANGE);

    assert_status_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wp_status));

    assert_tight_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && cur_state == WP_TIGHT) |-> tbl_val == WP_TIGHT);

    assert_open_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && cur_state == WP_OPEN && tbl_val == WP_TIGHT) |-> 1'b0);

    assert_last_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_wr && !last_wr) |=> last_addr == first_addr);

    assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && known && !busy) |=> busy);

    assert_err_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> $fell(busy));
endmodule

bind wp_lock_ctrl wpl_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .first_wr(first_wr), .last_wr(last_wr),
    .first_addr(first_addr), .last_addr(last_addr),
    .busy(busy), .cmd_err(cmd_err), .wp_status(wp_status), .irq(irq),
    .tbl_we(tbl_we), .cur_state(cur_state), .tbl_val(tbl_val)
);

// File: tb/sim_wp_lock_ctrl.sv
`timescale 1ns/1ps
module sim_wp_lock_ctrl;
    localparam int NBLK = 40;
    localparam int DW   = 16;
    localparam int AW   = 6;
    localparam logic [2:0] S_T = 3'b001, S_L = 3'b010, S_U = 3'b100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic          first_wr = 1'b0, last_wr = 1'b0;
    logic [DW-1:0] addr_wdata = '0;
    logic          irq_clr = 1'b0;
    logic [AW-1:0] qry_idx = '0;
    logic [2:0]    qry_state;
    logic [AW-1:0] first_addr, last_addr;
    logic          busy, cmd_err, irq;
    logic [2:0]    wp_status;

    wp_lock_ctrl #(.NBLK(NBLK), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .first_wr(first_wr), .last_wr(last_wr), .addr_wdata(addr_wdata),
        .irq_clr(irq_clr), .qry_idx(qry_idx), .qry_state(qry_state),
        .first_addr(first_addr), .last_addr(last_addr), .busy(busy),
        .cmd_err(cmd_err), .wp_status(wp_status), .irq(irq)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    // Reference model
    logic [2:0] m_tbl [NBLK];
    logic [2:0] m_wp;
    logic       m_err, m_irq;
    int         m_first, m_last;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NBLK; i++) m_tbl[i] = S_L;
        m_wp = S_L; m_err = 1'b0; m_irq = 1'b0; m_first = 0; m_last = 0;
    endtask

    function automatic logic known(input logic [7:0] c);
        return c == 8'h23 || c == 8'h27 || c == 8'h2A || c == 8'h2C;
    endfunction

    // Returns expected busy cycles
    task automatic model_cmd(input logic [7:0] c, output int cyc);
        int lo, hi;
        cyc = 0;
        if (!known(c)) return;
        lo = (c == 8'h27) ? 0 : m_first;
        hi = (c == 8'h27) ? NBLK - 1 : m_last;
        m_err = 1'b0;
        for (int i = lo; i < 200; i++) begin
            cyc++;
            if (i > hi) break;
            if (i >= NBLK) begin m_err = 1'b1; break; end
            if (m_tbl[i] == S_T && c != 8'h2C) break;
            if (c == 8'h2C) begin
                if (m_tbl[i] != S_U) begin m_tbl[i] = S_T; m_wp = S_T; end
            end else begin
                m_tbl[i] = (c == 8'h2A) ? S_L : S_U;
                m_wp = m_tbl[i];
            end
        end
        m_irq = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr_first(input int v);
        @(negedge clk); first_wr = 1'b1; addr_wdata = DW'(v);
        @(negedge clk); first_wr = 1'b0;
        m_first = v & 63; m_last = v & 63;
    endtask

    task automatic wr_last(input int v);
        @(negedge clk); last_wr = 1'b1; addr_wdata = DW'(v);
        @(negedge clk); last_wr = 1'b0;
        m_last = v & 63;
    endtask

    task automatic clr_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        m_irq = 1'b0;
    endtask

    // Issue a command; optionally inject a second command while busy
    task automatic run_cmd(input logic [7:0] c, input logic inject, input string tag);
        int exp_cyc, cnt;
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0;
        model_cmd(c, exp_cyc);
        cnt = 0;
        while (busy && cnt < 300) begin
            if (inject && cnt == 0) begin cmd_valid = 1'b1; cmd_code = 8'h2C; end
            else cmd_valid = 1'b0;
            cnt++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(cnt == exp_cyc, {tag, " busy cycles R11"}, cnt, exp_cyc);
        check(cmd_err == m_err, {tag, " cmd_err R7"}, cmd_err, m_err);
        check(wp_status == m_wp, {tag, " wp_status R9"}, wp_status, m_wp);
        check(irq == m_irq, {tag, " irq R10"}, irq, m_irq);
    endtask

    task automatic check_table(input string tag);
        int bad = -1;
        logic [2:0] got = '0;
        for (int i = 0; i < NBLK; i++) begin
            qry_idx = AW'(i);
            #1;
            if (bad < 0 && qry_state != m_tbl[i]) begin bad = i; got = qry_state; end
        end
        if (bad < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, {tag, $sformatf(" block %0d", bad)}, got, m_tbl[bad]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        do_reset();
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && cmd_err == 1'b0 && irq == 1'b0, "R1 reset flags", {busy, cmd_err, irq}, 0);
        check(wp_status == S_L, "R1 reset wp_status", wp_status, S_L);
        check_table("R1 reset table all locked");

        // R8: address registers
        wr_first(16'h01C5);
        check(first_addr == 6'h05 && last_addr == 6'h05, "R8 first loads last, masked",
              {first_addr, last_addr}, {6'h05, 6'h05});
        wr_last(16'h00CA);
        check(first_addr == 6'h05 && last_addr == 6'h0A, "R8 last write alone",
              {first_addr, last_addr}, {6'h05, 6'h0A});

        // R6: unlock all
        run_cmd(8'h27, 1'b0, "R6 unlock all");
        check_table("R6 table");
        clr_irq();
        check(irq == 1'b0, "R10 irq cleared", irq, 0);

        // R3: lock 0..9
        wr_first(0); wr_last(9);
        run_cmd(8'h2A, 1'b0, "R3 lock range");
        check_table("R3 table");

        // R5: lock-tight 8..14 over locked and unlocked blocks
        wr_first(8); wr_last(14);
        run_cmd(8'h2C, 1'b0, "R5 tight range");
        check_table("R5 table");

        // R4: unlock 6..12 stops at block 8
        wr_first(6); wr_last(12);
        run_cmd(8'h23, 1'b0, "R4 unlock stops");
        check_table("R4 table after unlock");
        // R2: unlock 2..5, with a command injected while busy (R11)
        wr_first(2); wr_last(5);
        run_cmd(8'h23, 1'b1, "R2 unlock range");
        check_table("R2 and R11 table");
        // R4: lock walk also stops at tight block
        wr_first(7); wr_last(20);
        run_cmd(8'h2A, 1'b0, "R4 lock stops");
        check_table("R4 table after lock");
        // R12: first above last
        clr_irq();
        wr_first(30); wr_last(20);
        run_cmd(8'h2A, 1'b0, "R12 empty range");
        check_table("R12 table");
        // R7: walk past block count
        wr_first(37); wr_last(50);
        run_cmd(8'h2A, 1'b0, "R7 overrun");
        check_table("R7 table");
        wr_first(45);
        run_cmd(8'h23, 1'b0, "R7 start beyond");
        wr_first(0); wr_last(1);
        run_cmd(8'h2A, 1'b0, "R7 err cleared");
        // R11: unknown code has no effect
        clr_irq();
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h55;
        @(negedge clk); cmd_valid = 1'b0;
        check(busy == 1'b0 && irq == 1'b0, "R11 unknown code ignored", {busy, irq}, 0);
        check_table("R11 table after unknown");

        // Random mix
        for (int it = 0; it < 160; it++) begin
            int sel, f, l;
            logic [7:0] c;
            if (it % 40 == 0) do_reset();
            sel = $urandom_range(0, 9);
            c = (sel < 3) ? 8'h23 : (sel < 6) ? 8'h2A : (sel < 8) ? 8'h2C : (sel < 9) ? 8'h27 : 8'h61;
            f = $urandom_range(0, 47);
            l = f + $urandom_range(0, 12) - 2;
            if (l < 0) l = 0;
            wr_first(f);
            if ($urandom_range(0, 3) != 0) wr_last(l);
            if ($urandom_range(0, 1) == 0) clr_irq();
            if (known(c)) begin
                run_cmd(c, $urandom_range(0, 3) == 0, $sformatf("rand %0d code %0h R2 R3 R5", it, c));
            end else begin
                @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
                @(negedge clk); cmd_valid = 1'b0;
                check(busy == 1'b0, "R11 random unknown", busy, 0);
            end
            check_table($sformatf("rand %0d table R4", it));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule